// File: doc/BRIEF.md
# Packet-Gated Streaming Word Buffer

This block is a single-clock buffer of 32-bit words between a processor-side write port and a streaming processing core. Words written by the processor are held until a whole packet is stored. Only then does the output side release that packet as one framed burst over a valid/ready handshake, with a start marker on the first word and an end marker on the last.

Two configuration inputs set the packet length and a fill threshold. The threshold drives a packet-ready flag, which lets the write side or a transfer engine see that a packet is nearly complete. By default the threshold is set just below the packet length (1022 against 1024). The storage holds two default packets (2048 words), so the next packet can be written while the current one drains. The block samples both configuration inputs only while no packet is streaming, so a packet in flight keeps the length it started with. A write into a full buffer is discarded and latches an overflow flag.

Top module: `pkt_gate_fifo`

## Requirements
- R1: After reset, fill_level is 0 and pkt_ready, overflow, out_valid, out_sop and out_eop are all 0.
- R2: A write while the buffer is not full and no word is read raises fill_level by exactly 1. The new value is visible on the cycle after the write strobe.
- R3: A write while fill_level equals the depth (2048) is discarded. fill_level stays at the depth and overflow goes to 1 on the next cycle. overflow then stays 1 until reset, and the discarded word never appears at the output.
- R4: pkt_ready is 1 exactly when fill_level is at or above the sampled threshold.
- R5: out_valid stays 0 until fill_level has reached the sampled packet length. It rises one cycle after the write that completes the packet.
- R6: A packet carries exactly the sampled length of words, in write order. out_sop is 1 only on the first word and out_eop only on the last. out_valid drops on the cycle after the handshake of the last word.
- R7: The output advances only on a cycle where out_valid and out_ready are both 1. While out_ready is 0, the data and markers hold steady.
- R8: A write and a handshake in the same cycle leave fill_level unchanged.
- R9: Changes to the length and threshold inputs during a packet have no effect on that packet. They take effect for the threshold flag and the next packet once the buffer is idle.
- R10: out_ready asserted while out_valid is 0 removes no word, so fill_level does not fall.
- R11: Two packets written back to back into the buffer drain as two complete, correctly framed packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe from the processor side |
| wr_data | input | 32 | Word to store |
| thr_cfg | input | 12 | Packet-ready threshold, sampled between packets |
| len_cfg | input | 12 | Packet length in words, sampled between packets (0 disables output) |
| fill_level | output | 12 | Number of stored words |
| pkt_ready | output | 1 | Fill level at or above the sampled threshold |
| overflow | output | 1 | Sticky flag: a write was dropped while full |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |

## Verification
A read or write pointer that goes wrong shows up at the ports as a wrong out_data word on the very next handshake, because the bench compares every beat with its own record of the writes. A beat counter that goes wrong moves out_eop, which the bench sees within one packet as a wrong final word or a packet that does not end. A fill count that drifts from the true occupancy changes fill_level on the next cycle. It also moves the moment out_valid rises and the moment pkt_ready flips, which the bench checks on the exact cycle.

// File: rtl/pgf_pkg.sv
// Package: shared types for the packet-gated buffer.
// Assumes: nothing beyond a single clock domain.
package pgf_pkg;
    typedef enum logic [0:0] {
        PGF_IDLE  = 1'b0,
        PGF_BURST = 1'b1
    } pgf_state_t;
endpackage

// File: rtl/pgf_store.sv
// pgf_store: circular word storage with read/write pointers and an occupancy count.
// Writes while full are refused and reported on wr_drop; reads while empty are refused.
// Assumes: DEPTH is a power of two; rd_data is the word at the read pointer (async read).
module pgf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              full,
    output logic              wr_drop
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL_LV = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic              wr_ok;
    logic              rd_ok;

    // Accept/refuse decisions for this cycle.
    always_comb begin
        full    = (level == FULL_LV);
        wr_ok   = wr_en && !full;
        rd_ok   = rd_en && (level != '0);
        wr_drop = wr_en && full;
        rd_data = mem[rd_ptr];
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and occupancy bookkeeping, balanced for simultaneous read and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pgf_framer.sv
// pgf_framer: decides when a packet may leave and frames it with start/end markers.
// While idle it samples the length and threshold inputs every cycle; it starts a burst
// once the stored count reaches the sampled length, then holds both values until the
// last word is accepted. A sampled length of zero, or one above the depth, never starts.
// Assumes: the store always holds at least the remaining words of a started packet.
module pgf_framer
    import pgf_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int DEF_LEN = 1024,
    parameter int DEF_THR = 1022
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] thr_cfg,
    input  logic [CNT_W-1:0] len_cfg,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic             rd_en,
    output logic             pkt_ready
);
    pgf_state_t       state;
    logic [CNT_W-1:0] cur_len;
    logic [CNT_W-1:0] cur_thr;
    logic [CNT_W-1:0] beat;
    logic             start;
    logic             last;

    // Start condition, framing markers and threshold flag.
    always_comb begin
        start     = (state == PGF_IDLE) && (cur_len != '0) && (level >= cur_len);
        last      = (beat == cur_len - 1'b1);
        out_valid = (state == PGF_BURST);
        out_sop   = out_valid && (beat == '0);
        out_eop   = out_valid && last;
        rd_en     = out_valid && out_ready;
        pkt_ready = (level >= cur_thr);
    end

    // Burst sequencing and between-packet sampling of the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PGF_IDLE;
            cur_len <= CNT_W'(DEF_LEN);
            cur_thr <= CNT_W'(DEF_THR);
            beat    <= '0;
        end else begin
            case (state)
                PGF_IDLE: begin
                    beat <= '0;
                    if (start) begin
                        state <= PGF_BURST;
                    end else begin
                        cur_len <= len_cfg;
                        cur_thr <= thr_cfg;
                    end
                end
                default: begin
                    if (out_ready) begin
                        beat <= beat + 1'b1;
                        if (last) state <= PGF_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pkt_gate_fifo.sv
// pkt_gate_fifo: word buffer whose output is gated until a full packet is stored,
// then streamed as one framed burst. Also reports fill level, a threshold flag and
// a sticky overflow flag.
// Assumes: one clock; DEPTH a power of two; synchronous active-low reset.
module pkt_gate_fifo #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 2048,
    parameter int DEF_LEN = 1024,
    parameter int DEF_THR = 1022,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  thr_cfg,
    input  logic [CNT_W-1:0]  len_cfg,
    output logic [CNT_W-1:0]  fill_level,
    output logic              pkt_ready,
    output logic              overflow,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop
);
    logic rd_en;
    logic full;
    logic wr_drop;

    pgf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (out_data),
        .level   (fill_level),
        .full    (full),
        .wr_drop (wr_drop)
    );

    pgf_framer #(
        .CNT_W   (CNT_W),
        .DEF_LEN (DEF_LEN),
        .DEF_THR (DEF_THR)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (fill_level),
        .thr_cfg   (thr_cfg),
        .len_cfg   (len_cfg),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .rd_en     (rd_en),
        .pkt_ready (pkt_ready)
    );

    // Sticky record of any write refused because the store was full.
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else if (wr_drop) overflow <= 1'b1;
    end
endmodule

// File: rtl/pkt_gate_fifo_chk.sv
// pkt_gate_fifo_chk: port-level temporal checks on pkt_gate_fifo, attached by bind.
module pkt_gate_fifo_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CNT_W-1:0]  fill_level,
    input logic              overflow,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop
);
    localparam logic [CNT_W-1:0] FULL_LV = CNT_W'(DEPTH);

    assert_write_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_level != FULL_LV && !out_valid) |=> fill_level == $past(fill_level) + 1'b1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_level == FULL_LV && !out_valid) |=> (fill_level == FULL_LV && overflow));

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_stream_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fill_level != '0);

    assert_markers_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    assert_eop_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    assert_level_balanced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_level != FULL_LV && out_valid && out_ready) |=> $stable(fill_level));

    assert_idle_ready_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> fill_level >= $past(fill_level));
endmodule

bind pkt_gate_fifo pkt_gate_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .fill_level (fill_level),
    .overflow   (overflow),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .out_eop    (out_eop)
);

// File: tb/sim_pkt_gate_fifo.sv
// sim_pkt_gate_fifo: directed bench, one task per scenario, each checking its own results.
module sim_pkt_gate_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [11:0] thr_cfg = 12'd6;
    logic [11:0] len_cfg = 12'd8;
    logic [11:0] fill_level;
    logic        pkt_ready;
    logic        overflow;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] model [0:8191];
    int w_idx = 0;
    int r_idx = 0;

    always #10 clk = ~clk;

    pkt_gate_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .thr_cfg(thr_cfg), .len_cfg(len_cfg), .fill_level(fill_level),
        .pkt_ready(pkt_ready), .overflow(overflow), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: inputs set at a negedge are taken at the posedge; return at the next negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        model[w_idx] = w;
        w_idx++;
        step();
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 ^ (i * 32'h0001_0203);
    endfunction

    task automatic wait_valid(input string tag);
        int t = 0;
        while (!out_valid && t < 200) begin
            step();
            t++;
        end
        chk(out_valid, tag, 64'(out_valid), 64'd1);
    endtask

    task automatic set_cfg(input int len, input int thr);
        len_cfg = 12'(len);
        thr_cfg = 12'(thr);
        step();
        step();
    endtask

    // Receive one packet of len words; stall inserts ready-low cycles.
    task automatic recv(input int len, input bit stall, input string tag);
        int i = 0;
        int cyc = 0;
        wait_valid({tag, " start"});
        while (i < len) begin
            logic rdy;
            rdy = stall ? (cyc % 3 != 2) : 1'b1;
            out_ready = rdy;
            if (!out_valid) begin
                chk(1'b0, {tag, " valid mid-packet"}, 64'(out_valid), 64'd1);
                break;
            end
            chk(out_data == model[r_idx], {tag, " data"}, 64'(out_data), 64'(model[r_idx]));
            chk(out_sop == (i == 0) && out_eop == (i == len - 1), {tag, " markers R6"},
                64'({out_sop, out_eop}), 64'({(i == 0), (i == len - 1)}));
            if (rdy) begin
                r_idx++;
                i++;
            end
            step();
            cyc++;
        end
        out_ready = 1'b0;
        chk(!out_valid, {tag, " valid drops after last R6"}, 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        chk(fill_level == 0 && !pkt_ready && !overflow, "R1 reset flags",
            64'({fill_level, pkt_ready, overflow}), 64'd0);
        chk(!out_valid && !out_sop && !out_eop, "R1 reset stream",
            64'({out_valid, out_sop, out_eop}), 64'd0);
        step();
    endtask

    // R2, R4, R5: counting, threshold flag, output gating.
    task automatic t_gate();
        set_cfg(8, 6);
        for (int i = 0; i < 7; i++) begin
            push(pat(w_idx));
            chk(fill_level == 12'(i + 1), "R2 level after write", 64'(fill_level), 64'(i + 1));
            chk(pkt_ready == (i + 1 >= 6), "R4 threshold flag", 64'(pkt_ready), 64'(i + 1 >= 6));
            chk(!out_valid, "R5 gated before full packet", 64'(out_valid), 64'd0);
        end
        push(pat(w_idx));
        chk(!out_valid, "R5 not valid on completing write", 64'(out_valid), 64'd0);
        step();
        chk(out_valid && out_sop, "R5 valid one cycle later", 64'({out_valid, out_sop}), 64'd3);
        recv(8, 1'b1, "R7 stalled drain");
        chk(fill_level == 0 && !pkt_ready, "R4 flag clears when drained",
            64'({fill_level, pkt_ready}), 64'd0);
    endtask

    // R8: simultaneous write and handshake.
    task automatic t_simul();
        set_cfg(4, 3);
        for (int i = 0; i < 4; i++) push(pat(w_idx));
        wait_valid("R8 start");
        for (int i = 0; i < 4; i++) begin
            out_ready = 1'b1;
            wr_en = 1'b1;
            wr_data = pat(w_idx);
            model[w_idx] = wr_data;
            w_idx++;
            chk(out_data == model[r_idx], "R8 data", 64'(out_data), 64'(model[r_idx]));
            step();
            r_idx++;
            chk(fill_level == 12'd4, "R8 level unchanged", 64'(fill_level), 64'd4);
        end
        wr_en = 1'b0;
        out_ready = 1'b0;
        recv(4, 1'b0, "R8 second packet");
    endtask

    // R9: configuration changes during a packet.
    task automatic t_cfg();
        set_cfg(8, 6);
        for (int i = 0; i < 8; i++) push(pat(w_idx));
        wait_valid("R9 start");
        len_cfg = 12'd3;
        thr_cfg = 12'd1;
        recv(8, 1'b0, "R9 length held");
        step();
        chk(!pkt_ready, "R9 empty after packet", 64'(pkt_ready), 64'd0);
        push(pat(w_idx));
        chk(pkt_ready, "R9 new threshold applies", 64'(pkt_ready), 64'd1);
        push(pat(w_idx));
        push(pat(w_idx));
        recv(3, 1'b0, "R9 new length");
    endtask

    // R10: ready while not valid.
    task automatic t_idle_ready();
        set_cfg(8, 6);
        push(pat(w_idx));
        push(pat(w_idx));
        out_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk(fill_level == 12'd2 && !out_valid, "R10 level kept",
                64'({out_valid, fill_level}), 64'd2);
        end
        out_ready = 1'b0;
        for (int i = 0; i < 6; i++) push(pat(w_idx));
        recv(8, 1'b1, "R10 packet");
    endtask

    // R11: two packets stored before draining.
    task automatic t_back2back();
        set_cfg(16, 14);
        for (int i = 0; i < 32; i++) push(pat(w_idx));
        chk(fill_level == 12'd32, "R11 two packets stored", 64'(fill_level), 64'd32);
        recv(16, 1'b0, "R11 first");
        recv(16, 1'b1, "R11 second");
    endtask

    // R3: write into a full store.
    task automatic t_overflow();
        set_cfg(1024, 1022);
        for (int i = 0; i < 2048; i++) push(pat(w_idx));
        chk(fill_level == 12'd2048 && pkt_ready, "R3 full",
            64'({pkt_ready, fill_level}), 64'({1'b1, 12'd2048}));
        chk(!overflow, "R3 no overflow yet", 64'(overflow), 64'd0);
        wr_en = 1'b1;
        wr_data = 32'hDEAD_BEEF;
        step();
        wr_en = 1'b0;
        chk(fill_level == 12'd2048 && overflow, "R3 write dropped",
            64'({overflow, fill_level}), 64'({1'b1, 12'd2048}));
        recv(1024, 1'b0, "R3 drain 1");
        recv(1024, 1'b0, "R3 drain 2");
        chk(overflow && fill_level == 0, "R3 sticky after drain",
            64'({overflow, fill_level}), 64'({1'b1, 12'd0}));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_gate();
        t_simul();
        t_cfg();
        t_idle_ready();
        t_back2back();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule